// File: doc/BRIEF.md
# Periodic Serial Converter Read Controller

This block sits on the host side of a 14-bit successive-approximation converter that has a three-wire serial port: an active-low select, a data clock driven by the host, and one data line driven by the converter. It produces the select and the data clock from the system clock. A programmable half-period divider sets the clock rate. A programmable frame period, counted in data-clock periods, sets how often a read starts. Between reads the select line stays high, so the converter sits in full power-down and its output floats.

In each read the controller ignores the bits that appear during the converter's input sample window. It checks that a low null bit comes first, shifts in fourteen result bits with the most significant first, and checks that two zero bits follow. It then releases the select line, which stops the converter from sending the word again in reverse order. The code is two's complement. It is sign-extended to the host word width and presented with a one-cycle strobe, together with a flag that marks a bad frame. Data-clock low time must exceed the converter's output delay, so the divider setting is chosen to keep each half period longer than 250 ns.

Top module: `adc_frame_reader`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `adc_cs_n` is 1, `adc_sclk` is 0, `sample_valid` is 0 and `frame_err` is 0.
- R2: Within a frame, every high phase and every low phase of `adc_sclk` lasts exactly `cfg_half`+1 system cycles. The low phase between the fall of `adc_cs_n` and the first rising edge is included.
- R3: Each frame lowers `adc_cs_n` with `adc_sclk` low and gives exactly 22 rising clock edges. `adc_cs_n` rises on the same cycle as the falling edge that follows rising edge 22. `adc_sclk` is low whenever `adc_cs_n` is high.
- R4: While `run` is high, consecutive falls of `adc_cs_n` are 2·P·(`cfg_half`+1) system cycles apart, where P is `cfg_period` (in data-clock periods).
- R5: The bits on `adc_sdo` at rising edges 7 to 20, counted from the fall of `adc_cs_n`, form the code from bit 13 down to bit 0. `sample` is that 14-bit two's-complement code sign-extended to OUT_W bits.
- R6: `sample_valid` is a single-cycle pulse. It is raised on the system cycle after rising edge 22 of each frame, exactly once per frame.
- R7: `frame_err` is 1 together with `sample_valid` when `adc_sdo` is 1 at rising edge 6 (the null bit), edge 21 or edge 22. Otherwise it is 0.
- R8: The level of `adc_sdo` at rising edges 1 to 5 changes neither `sample` nor `frame_err`.
- R9: When `cfg_period` is below 23, the frame period is 23 data-clock periods. `adc_cs_n` then stays high for at least one full data-clock period between frames.
- R10: After `run` goes low, a frame already started completes and no further frame starts, so `adc_cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables periodic reads |
| cfg_half | input | HALF_W | Data-clock half period minus one, in system cycles |
| cfg_period | input | PER_W | Frame period in data-clock periods (minimum 23 applied) |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Data clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| sample | output | OUT_W | Sign-extended signed result |
| sample_valid | output | 1 | One-cycle strobe for a new result |
| frame_err | output | 1 | Framing bit error, valid with the strobe |

## Verification
The bench models the converter: it changes its data after each falling clock edge and drives ones during the sample window. This means a controller that counted edges from the wrong origin would shift junk ones into the code, and a controller with an off-by-one skip would report a false framing error. Codes at both ends of the range, minus one and zero show whether the sign extension is done right. A single high bit placed in turn on the null position and on each tail position shows whether a check is missing. A period setting below the minimum, timed against the expected clamp, catches a controller that runs frames back to back. Lowering `run` after a known frame count catches a controller that keeps reading.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int CODE_W          = 14;
    localparam int EDGE_W          = 5;
    localparam int NULL_EDGE       = 6;
    localparam int FIRST_DATA_EDGE = 7;
    localparam int LAST_DATA_EDGE  = FIRST_DATA_EDGE + CODE_W - 1;
    localparam int LAST_EDGE       = LAST_DATA_EDGE + 2;
    localparam int MIN_PERIOD      = LAST_EDGE + 1;

    typedef enum logic [1:0] {
        EK_SKIP,
        EK_NULL,
        EK_DATA,
        EK_TAIL
    } edge_kind_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              bad;
    } capture_t;

    function automatic edge_kind_e classify_edge(input logic [EDGE_W-1:0] idx);
        if (int'(idx) == NULL_EDGE)
            return EK_NULL;
        else if (int'(idx) >= FIRST_DATA_EDGE && int'(idx) <= LAST_DATA_EDGE)
            return EK_DATA;
        else if (int'(idx) > LAST_DATA_EDGE && int'(idx) <= LAST_EDGE)
            return EK_TAIL;
        return EK_SKIP;
    endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_q;

    assign tick = (cnt_q >= half);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int PER_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic [PER_W-1:0]  period,
    output logic              cs_n,
    output logic              sclk,
    output logic              rise,
    output logic [EDGE_W-1:0] rise_idx
);
    localparam int CNT_W = PER_W + 1;

    logic              in_frame_q;
    logic              cs_n_q;
    logic              sclk_q;
    logic [EDGE_W-1:0] edge_q;
    logic [CNT_W-1:0]  wait_q;
    logic [PER_W-1:0]  eff_period;
    logic [CNT_W-1:0]  reload;

    assign eff_period = (int'(period) < MIN_PERIOD) ? PER_W'(MIN_PERIOD) : period;
    assign reload     = {eff_period, 1'b0} - 1'b1;

    assign cs_n     = cs_n_q;
    assign sclk     = sclk_q;
    assign rise     = tick && in_frame_q && !sclk_q;
    assign rise_idx = edge_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            cs_n_q     <= 1'b1;
            sclk_q     <= 1'b0;
            edge_q     <= '0;
            wait_q     <= '0;
        end else if (tick) begin
            if (!in_frame_q && wait_q == '0) begin
                if (run) begin
                    in_frame_q <= 1'b1;
                    cs_n_q     <= 1'b0;
                    edge_q     <= '0;
                    wait_q     <= reload;
                end
            end else begin
                if (wait_q != '0)
                    wait_q <= wait_q - 1'b1;
                if (in_frame_q) begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        edge_q <= rise_idx;
                    end else begin
                        sclk_q <= 1'b0;
                        if (int'(edge_q) == LAST_EDGE) begin
                            in_frame_q <= 1'b0;
                            cs_n_q     <= 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
    import adc_rd_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rise,
    input  logic [EDGE_W-1:0]       rise_idx,
    input  logic                    sdo,
    output logic signed [OUT_W-1:0] sample,
    output logic                    valid,
    output logic                    err
);
    capture_t          acc_q;
    logic [OUT_W-1:0]  widened;

    generate
        if (OUT_W > CODE_W) begin : g_extend
            assign widened = {{(OUT_W-CODE_W){acc_q.code[CODE_W-1]}}, acc_q.code};
        end else begin : g_exact
            assign widened = acc_q.code[OUT_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            sample <= '0;
            valid  <= 1'b0;
            err    <= 1'b0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            if (rise) begin
                unique case (classify_edge(rise_idx))
                    EK_NULL: acc_q.bad  <= sdo;
                    EK_DATA: acc_q.code <= {acc_q.code[CODE_W-2:0], sdo};
                    EK_TAIL: begin
                        acc_q.bad <= acc_q.bad | sdo;
                        if (int'(rise_idx) == LAST_EDGE) begin
                            valid  <= 1'b1;
                            sample <= widened;
                            err    <= acc_q.bad | sdo;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int OUT_W  = 16,
    parameter int HALF_W = 8,
    parameter int PER_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic [HALF_W-1:0]       cfg_half,
    input  logic [PER_W-1:0]        cfg_period,
    output logic                    adc_cs_n,
    output logic                    adc_sclk,
    input  logic                    adc_sdo,
    output logic signed [OUT_W-1:0] sample,
    output logic                    sample_valid,
    output logic                    frame_err
);
    logic              tick;
    logic              rise;
    logic [EDGE_W-1:0] rise_idx;

    adc_rd_tick #(.HALF_W(HALF_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .half (cfg_half),
        .tick (tick)
    );

    adc_rd_seq #(.PER_W(PER_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (run),
        .period   (cfg_period),
        .cs_n     (adc_cs_n),
        .sclk     (adc_sclk),
        .rise     (rise),
        .rise_idx (rise_idx)
    );

    adc_rd_capture #(.OUT_W(OUT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .rise_idx (rise_idx),
        .sdo      (adc_sdo),
        .sample   (sample),
        .valid    (sample_valid),
        .err      (frame_err)
    );
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int HALF_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [HALF_W-1:0] cfg_half,
    input logic              adc_cs_n,
    input logic              adc_sclk,
    input logic              sample_valid,
    input logic              frame_err
);
    logic        sclk_d;
    logic [5:0]  rise_cnt;
    logic [15:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
            gap_cnt  <= '1;
        end else begin
            sclk_d <= adc_sclk;
            if (adc_cs_n)
                rise_cnt <= '0;
            else if (adc_sclk && !sclk_d)
                rise_cnt <= rise_cnt + 1'b1;
            if (!adc_cs_n)
                gap_cnt <= '0;
            else if (gap_cnt != '1)
                gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R3: clock idles low while deselected
    p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> !adc_sclk);

    // R3: 22 rising edges per frame
    p_edge_count_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> rise_cnt == 6'd22);

    // R6: strobe is one cycle wide
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R6: strobe lands during the high phase after the last rising edge
    p_valid_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (!adc_cs_n && adc_sclk));

    // R7: error flag only with the strobe
    p_err_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> sample_valid);

    // R9: deselect lasts at least one full data-clock period
    p_min_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> (gap_cnt >= 16'(2 * (int'(cfg_half) + 1))));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.HALF_W(HALF_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_half     (cfg_half),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .sample_valid (sample_valid),
    .frame_err    (frame_err)
);

// File: tb/adc_frame_reader_tb.sv
`timescale 1ns/1ps
module adc_frame_reader_tb;
    localparam int OUT_W  = 16;
    localparam int HALF_W = 8;
    localparam int PER_W  = 10;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    run = 1'b0;
    logic [HALF_W-1:0]       cfg_half = '0;
    logic [PER_W-1:0]        cfg_period = 10'd23;
    logic                    adc_cs_n;
    logic                    adc_sclk;
    logic                    adc_sdo = 1'b0;
    logic signed [OUT_W-1:0] sample;
    logic                    sample_valid;
    logic                    frame_err;

    always #2.5 clk = ~clk;

    adc_frame_reader #(.OUT_W(OUT_W), .HALF_W(HALF_W), .PER_W(PER_W)) u_dut (
        .clk(clk), .rst(rst), .run(run), .cfg_half(cfg_half), .cfg_period(cfg_period),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
        .sample(sample), .sample_valid(sample_valid), .frame_err(frame_err)
    );

    typedef struct {
        logic [13:0] code;
        bit nul, t1, t2, junk;
    } stim_t;

    typedef struct {
        logic signed [OUT_W-1:0] v;
        bit                      e;
        string                   tag;
    } exp_t;

    stim_t stim_q[$];
    exp_t  exp_q[$];
    stim_t cur;

    int checks = 0;
    int failures = 0;
    int cyc = 0, last_fall = 0, last_period = 0, falls = 0;
    int rises = 0, hi_run = 0, lo_run = 0, bad_half = 0, bad_edges = 0;
    int fcnt = 0, vcount = 0, cur_h = 0;
    bit cs_d = 1'b1, sclk_d = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_frame(input logic [13:0] code, input bit nul, input bit t1,
                              input bit t2, input bit junk, input string tag);
        stim_t s;
        exp_t  x;
        s.code = code; s.nul = nul; s.t1 = t1; s.t2 = t2; s.junk = junk;
        stim_q.push_back(s);
        x.v = {{(OUT_W-14){code[13]}}, code};
        x.e = nul | t1 | t2;
        x.tag = tag;
        exp_q.push_back(x);
    endtask

    function automatic logic bit_after_fall(input stim_t s, input int f);
        if (f < 5)   return s.junk;
        if (f == 5)  return s.nul;
        if (f <= 19) return s.code[19-f];
        if (f == 20) return s.t1;
        if (f == 21) return s.t2;
        return s.code[(f-22) % 14];
    endfunction

    // converter model, bus observation and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (cs_d && !adc_cs_n) begin
            if (stim_q.size() > 0) cur = stim_q.pop_front();
            else begin cur.code = '0; cur.nul = 0; cur.t1 = 0; cur.t2 = 0; cur.junk = 0; end
            fcnt = 0;
            adc_sdo = cur.junk;
            falls++;
            if (last_fall > 0) last_period = cyc - last_fall;
            last_fall = cyc;
            rises = 0; hi_run = 0; lo_run = 0;
        end else if (!adc_cs_n && sclk_d && !adc_sclk) begin
            fcnt++;
            adc_sdo = bit_after_fall(cur, fcnt);
        end
        if (sclk_d && !adc_sclk) begin
            if (hi_run != cur_h + 1) bad_half++;
            hi_run = 0;
        end
        if (!sclk_d && adc_sclk) begin
            if (lo_run != cur_h + 1) bad_half++;
            lo_run = 0;
            rises++;
        end
        if (!cs_d && adc_cs_n && rises != 22) bad_edges++;
        if (!adc_cs_n) begin
            if (adc_sclk) hi_run++; else lo_run++;
        end
        if (sample_valid) begin
            vcount++;
            if (exp_q.size() == 0) begin
                check(0, "R6", "unexpected strobe", 1, 0);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(sample == x.v, x.tag, "sample value", sample, x.v);
                check(frame_err == x.e, (x.tag == "R8") ? "R8" : "R7", "frame_err", frame_err, x.e);
            end
        end
        cs_d = adc_cs_n;
        sclk_d = adc_sclk;
    end

    task automatic run_block(input int h, input int p, input int n, input int exp_per);
        int f0;
        int guard;
        rst = 1'b1;
        run = 1'b0;
        cfg_half = HALF_W'(h);
        cfg_period = PER_W'(p);
        cur_h = h;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        falls = 0; last_fall = 0; last_period = 0; vcount = 0;
        bad_half = 0; bad_edges = 0;
        run = 1'b1;
        while (falls < n) @(negedge clk);
        run = 1'b0;
        guard = 0;
        while (exp_q.size() > 0 && guard < 4 * exp_per) begin
            @(negedge clk);
            guard++;
        end
        repeat (10) @(negedge clk);
        check(vcount == n, "R6", "strobes per frame", vcount, n);
        check(bad_half == 0, "R2", "half periods off", bad_half, 0);
        check(bad_edges == 0, "R3", "frames with wrong edge count", bad_edges, 0);
        if (n >= 2)
            check(last_period == exp_per, (p < 23) ? "R9" : "R4", "frame period", last_period, exp_per);
        f0 = falls;
        repeat (3 * exp_per) @(negedge clk);
        check(falls == f0 && adc_cs_n == 1'b1, "R10", "frames after run low", falls - f0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(adc_cs_n == 1'b1, "R1", "cs_n in reset", adc_cs_n, 1);
        check(adc_sclk == 1'b0, "R1", "sclk in reset", adc_sclk, 0);
        check(sample_valid == 1'b0 && frame_err == 1'b0, "R1", "strobe/err in reset",
              sample_valid + frame_err, 0);

        // block A: fastest clock, minimum period, value and framing patterns
        push_frame(14'h1FFF, 0, 0, 0, 1, "R5");
        push_frame(14'h2000, 0, 0, 0, 1, "R5");
        push_frame(14'h0000, 0, 0, 0, 1, "R8");
        push_frame(14'h3FFF, 0, 0, 0, 0, "R5");
        push_frame(14'h1555, 1, 0, 0, 0, "R5");
        push_frame(14'h2AAA, 0, 1, 0, 0, "R5");
        push_frame(14'h0001, 0, 0, 1, 0, "R5");
        push_frame(14'h0F0F, 0, 0, 0, 1, "R8");
        run_block(0, 23, 8, 2 * 23 * 1);

        // block B: slower divider and a longer period
        push_frame(14'h0ABC, 0, 0, 0, 1, "R5");
        push_frame(14'h3210, 0, 0, 0, 0, "R5");
        run_block(3, 40, 2, 2 * 40 * 4);

        // block C: period below the minimum is clamped
        push_frame(14'h1234, 0, 0, 0, 0, "R5");
        push_frame(14'h2345, 0, 0, 0, 1, "R8");
        push_frame(14'h3456, 1, 1, 1, 0, "R5");
        run_block(1, 5, 3, 2 * 23 * 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule